// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects 64 interrupt lines into two banks of 32 and presents them to a processor through a small register window and one active-high request wire. Each bank offers four words: latched events, enables, a write-one-to-clear acknowledge word and a raw line view. Lines are first brought into the clock domain through a synchronizer chain.

Most sources are edge type. A rising edge of the synchronized line, seen while the source is enabled, sets a sticky event bit. A fixed parameter mask marks some low-bank sources as level type. These are never latched and are reported straight from their synchronized line. Enabling an edge source whose line is already high does not count as an edge, so software has to poll the line view to see such a source.

A read-only vector word gives the highest-numbered pending source and a valid flag. Software reads it, services that source, acknowledges it, and reads the vector again.

Top module: `irq_bank_ctl`

## Requirements
- R1: Byte offsets within the 64-byte window: the vector word is at 0x00. The low bank (sources 0 to 31) is at 0x20 and the high bank (sources 32 to 63) is at 0x10. Within a bank the words are event +0x0, enable +0x4, acknowledge +0x8, line +0xC. Source n maps to bit n mod 32 of its bank. `reg_rdata` shows the word addressed in the previous cycle. Unmapped offsets read 0.
- R2: Reset clears all enable bits, all event bits, `irq_o` and the vector word.
- R3: Writing the acknowledge word clears the event bits written as 1 and leaves bits written as 0 untouched. The acknowledge word reads as 0.
- R4: Enable bits read back as written. A source whose enable bit is 0 is never pending, and with no enables set `irq_o` stays low.
- R5: Low-bank bits 20 to 28 (mask 0x1ff00000) are level type. They never set an event bit. They are pending while enabled and their synchronized line is high. The high bank has no level sources.
- R6: An enabled edge source sets its event bit on the third clock edge after its line rises. The bit stays set after the line falls. An edge that occurs while the source is disabled is lost.
- R7: Enabling an edge source whose line is already high sets no event bit and does not raise `irq_o`.
- R8: The line word returns the synchronized state of every line, whatever the enables are.
- R9: `irq_o` is the registered OR of all pending sources. It changes on the clock edge after the edge that captures an enable or acknowledge write.
- R10: The vector word holds the highest-numbered pending source in bits 5:0, with bit 31 set. It reads as 0 when nothing is pending. Any pending high-bank source therefore wins over every low-bank source.
- R11: Writes to the event word, the line word and the vector word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | 64 | Asynchronous interrupt lines, bit n is source n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's offset |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Read data is due one edge after the address is presented. `irq_o` follows an enable or acknowledge write by one edge beyond the edge that captures the write. An event latches three edges after its line rises, and a level source reaches `irq_o` after the same three edges. The bench drives every input on falling edges and samples on falling edges. Timing-critical checks, such as the request rising only one edge after an enable write, sample exactly at the first falling edge where the value is due, and also one edge before it. Line-driven checks wait a margin of extra cycles, since their exact latency is covered by the register-level timing checks.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int BANK_W = 32;
  localparam int NBANK  = 2;
  localparam int NSRC   = BANK_W * NBANK;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = $clog2(NSRC);

  typedef enum logic [1:0] {
    RS_EVENT  = 2'd0,
    RS_ENABLE = 2'd1,
    RS_ACK    = 2'd2,
    RS_LINE   = 2'd3
  } reg_slot_e;

  // address bits 5:4 selecting bank b: bank 0 at 0x20, bank 1 at 0x10
  function automatic logic [1:0] bank_window(input int b);
    return 2'(2 - b);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = dout & ~prev;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int             W   = 32,
  parameter logic [W-1:0]   LVL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line,
  input  logic [W-1:0] rise,
  input  logic         en_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en,
  output logic [W-1:0] evt,
  output logic [W-1:0] pend
);
  logic [W-1:0] clr;

  assign clr = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      evt <= '0;
    end else begin
      if (en_we) en <= wdata;
      // a fresh edge wins over a simultaneous acknowledge
      evt <= (evt & ~clr) | (rise & en & ~LVL);
    end
  end

  assign pend = en & (evt | (line & LVL));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |pend;
    idx   = '0;
    for (int i = 0; i < N; i++)
      if (pend[i]) idx = IW'(i);
  end
endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl
  import irq_bank_pkg::*;
#(
  parameter logic [NSRC-1:0] LEVEL_MASK  = 64'h0000_0000_1ff0_0000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_line,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0]  line_s, rise_all, en_all, evt_all, pend_all;
  logic             vec_valid;
  logic [IDX_W-1:0] vec_idx;
  logic [31:0]      rd_next;
  logic             aligned;

  assign aligned = (reg_addr[1:0] == 2'b00);

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(irq_line), .dout(line_s), .rise(rise_all)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [1:0] WIN = bank_window(b);
    logic hit;
    assign hit = reg_we && aligned && (reg_addr[5:4] == WIN);

    irq_bank #(.W(BANK_W), .LVL(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
      .clk    (clk),
      .rst    (rst),
      .line   (line_s  [b*BANK_W +: BANK_W]),
      .rise   (rise_all[b*BANK_W +: BANK_W]),
      .en_we  (hit && (reg_addr[3:2] == RS_ENABLE)),
      .ack_we (hit && (reg_addr[3:2] == RS_ACK)),
      .wdata  (reg_wdata),
      .en     (en_all  [b*BANK_W +: BANK_W]),
      .evt    (evt_all [b*BANK_W +: BANK_W]),
      .pend   (pend_all[b*BANK_W +: BANK_W])
    );
  end

  irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
    .pend(pend_all), .valid(vec_valid), .idx(vec_idx)
  );

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (reg_addr[5:2] == 4'd0) begin
        rd_next[31]        = vec_valid;
        rd_next[IDX_W-1:0] = vec_idx;
      end
      for (int b = 0; b < NBANK; b++) begin
        if (reg_addr[5:4] == bank_window(b)) begin
          case (reg_slot_e'(reg_addr[3:2]))
            RS_EVENT:  rd_next = evt_all[b*BANK_W +: BANK_W];
            RS_ENABLE: rd_next = en_all [b*BANK_W +: BANK_W];
            RS_LINE:   rd_next = line_s [b*BANK_W +: BANK_W];
            default:   rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq_o     <= vec_valid;
    end
  end
endmodule

// File: rtl/irq_bank_ctl_chk.sv
module irq_bank_ctl_chk
  import irq_bank_pkg::*;
#(
  parameter logic [NSRC-1:0] LVL = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic [NSRC-1:0]   en_all,
  input logic [NSRC-1:0]   evt_all,
  input logic [NSRC-1:0]   rise_all
);
  logic ack_lo;
  assign ack_lo = reg_we && (reg_addr == 6'h28);

  a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_all == '0 && !irq_o));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_lo |=> ((evt_all[31:0] & $past(reg_wdata)
                 & ~$past(rise_all[31:0] & en_all[31:0])) == '0));

  a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
    (en_all == '0) |=> !irq_o);

  a_r5_level_never_latched: assert property (@(posedge clk) disable iff (rst)
    (evt_all & LVL) == '0);

  a_r6_latch_only_enabled: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_all & ~$past(evt_all) & ~$past(en_all)) == '0));
endmodule

bind irq_bank_ctl irq_bank_ctl_chk #(.LVL(LEVEL_MASK)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .en_all(en_all),
  .evt_all(evt_all), .rise_all(rise_all)
);

// File: tb/irq_bank_ctl_test.sv
`timescale 1ns/1ps
module irq_bank_ctl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] irq_line = '0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  irq_bank_ctl uut (
    .clk(clk), .rst(rst), .irq_line(irq_line), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic int base_of(input int src);
    return (src < 32) ? 'h20 : 'h10;
  endfunction

  task automatic clean();
    irq_line = '0;
    tick(4);
    wr('h24, 0); wr('h14, 0);
    wr('h28, 32'hffff_ffff); wr('h18, 32'hffff_ffff);
    tick(2);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R2 reset state
    check("R2 irq after reset", {31'b0, irq_o}, 0);
    rd('h24, v); check("R2 low enables", v, 0);
    rd('h14, v); check("R2 high enables", v, 0);
    rd('h00, v); check("R2 vector", v, 0);
    rd('h20, v); check("R2 low events", v, 0);

    // R1 unmapped offsets
    rd('h30, v); check("R1 unmapped 0x30", v, 0);
    rd('h3C, v); check("R1 unmapped 0x3C", v, 0);

    // R4 enable readback
    wr('h14, 32'h8000_0001); rd('h14, v); check("R4 enable readback", v, 32'h8000_0001);
    wr('h14, 0);

    // R6 R10 R9 R3: sweep every edge source
    for (int i = 0; i < 64; i++) begin
      if (i >= 20 && i <= 28) continue;
      wr(base_of(i) + 4, 32'(1) << (i % 32));
      irq_line[i] = 1;
      tick(5);
      rd(base_of(i), v);      check($sformatf("R6 event src %0d", i), v, 32'(1) << (i % 32));
      rd('h00, v);            check($sformatf("R10 vector src %0d", i), v, 32'h8000_0000 | 32'(i));
      check($sformatf("R9 irq src %0d", i), {31'b0, irq_o}, 1);
      irq_line[i] = 0;
      tick(4);
      rd(base_of(i), v);      check($sformatf("R6 sticky src %0d", i), v, 32'(1) << (i % 32));
      wr(base_of(i) + 8, 32'(1) << (i % 32));
      check($sformatf("R9 irq held at ack edge src %0d", i), {31'b0, irq_o}, 1);
      tick(1);
      check($sformatf("R3 irq dropped src %0d", i), {31'b0, irq_o}, 0);
      rd(base_of(i), v);      check($sformatf("R3 cleared src %0d", i), v, 0);
      wr(base_of(i) + 4, 0);
    end

    // R5 R8 level sources
    for (int i = 20; i <= 28; i++) begin
      wr('h24, 32'(1) << i);
      irq_line[i] = 1;
      tick(4);
      check($sformatf("R5 level irq src %0d", i), {31'b0, irq_o}, 1);
      rd('h00, v); check($sformatf("R5 level vector src %0d", i), v, 32'h8000_0000 | 32'(i));
      rd('h20, v); check($sformatf("R5 no event src %0d", i), v, 0);
      rd('h2C, v); check($sformatf("R8 line src %0d", i), v, 32'(1) << i);
      irq_line[i] = 0;
      tick(4);
      check($sformatf("R5 level release src %0d", i), {31'b0, irq_o}, 0);
      wr('h24, 0);
    end

    // R8 line view independent of enable
    irq_line[45] = 1; tick(4);
    rd('h1C, v); check("R8 line view disabled src 45", v, 32'h0000_2000);
    clean();

    // R9 exact timing after enable write
    irq_line[20] = 1; tick(4);
    wr('h24, 32'(1) << 20);
    check("R9 irq not yet at write edge", {31'b0, irq_o}, 0);
    tick(1);
    check("R9 irq one edge later", {31'b0, irq_o}, 1);
    clean();

    // R7 enable while line already high
    irq_line[3] = 1; tick(5);
    wr('h24, 32'h8);
    tick(4);
    check("R7 no irq", {31'b0, irq_o}, 0);
    rd('h20, v); check("R7 no event", v, 0);
    clean();

    // R6 edge while disabled is lost
    irq_line[4] = 1; tick(5); irq_line[4] = 0; tick(4);
    wr('h24, 32'h10); tick(3);
    rd('h20, v); check("R6 lost edge event", v, 0);
    check("R6 lost edge irq", {31'b0, irq_o}, 0);
    clean();

    // R3 zero bits untouched, ack reads 0
    wr('h24, 32'h88);
    irq_line[3] = 1; irq_line[7] = 1; tick(5);
    irq_line[3] = 0; irq_line[7] = 0; tick(3);
    wr('h28, 32'h8);
    rd('h20, v); check("R3 zero bit keeps event", v, 32'h80);
    rd('h28, v); check("R3 ack reads zero", v, 0);
    clean();

    // R10 upper bank wins
    wr('h24, 32'h8000_0020); wr('h14, 32'h0000_0101);
    irq_line[31] = 1; irq_line[32] = 1; irq_line[5] = 1; irq_line[40] = 1;
    tick(5);
    rd('h00, v); check("R10 src 40 highest", v, 32'h8000_0028);
    wr('h18, 32'h100);
    rd('h00, v); check("R10 src 32 over 31", v, 32'h8000_0020);
    wr('h18, 32'h1);
    rd('h00, v); check("R10 src 31 next", v, 32'h8000_001F);
    wr('h28, 32'h8000_0000);
    rd('h00, v); check("R10 src 5 last", v, 32'h8000_0005);
    clean();
    rd('h00, v); check("R10 nothing pending", v, 0);

    // R11 ignored writes
    wr('h20, 32'hffff_ffff); wr('h2C, 32'hffff_ffff);
    wr('h00, 32'hffff_ffff); wr('h1C, 32'hffff_ffff);
    rd('h20, v); check("R11 event write ignored", v, 0);
    rd('h24, v); check("R11 enables untouched", v, 0);
    rd('h00, v); check("R11 vector write ignored", v, 0);
    check("R11 irq low", {31'b0, irq_o}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule